// File: doc/BRIEF.md
# Packed dual-source FP32-to-BF16 converter

This block takes two vectors of packed single-precision (FP32) values and turns them into one vector of packed BF16 values. Because each BF16 element is half the width of an FP32 element, the result holds twice as many elements as either source. The lower half of the result comes from the second source and the upper half from the first source. A broadcast option replaces every input with FP32 element 0 of the second source. All elements are converted in parallel, and the result is registered one cycle after a valid input.

Rounding is round-to-nearest-even. Denormal inputs become signed zero. No floating-point control or status state is consulted and no flags are produced. A per-element write mask can be enabled. Elements with a clear mask bit are either zeroed or keep the value of the old destination that comes with the request. The vector width is a parameter of 128, 256 or 512 bits. The result port is always the full maximum register width, and every bit above the vector width is zero.

Top module: `bf16_pack_cvt`

## Requirements
- R1: After reset `out_valid` is 0 and `result` is all zero. `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, so back-to-back requests give back-to-back results. The result has VEC_W/16 elements of 16 bits, with element i at bits [16i+15:16i].
- R2: With `bcast` low, result element i, for i below half the element count H, is converted from FP32 element i of `src_b` (bits [32i+31:32i]).
- R3: With `bcast` low, result element i, for i at or above H, is converted from FP32 element i-H of `src_a`.
- R4: With `bcast` high, every result element is converted from FP32 element 0 of `src_b`, and the other `src_b` elements and all of `src_a` are ignored.
- R5: Finite normal inputs are rounded to nearest with ties to even on the upper 16 bits. A carry out of the fraction increments the exponent, and values beyond the largest BF16 become infinity of the same sign.
- R6: An input with exponent field 0 (zero or denormal) yields a zero that keeps the input sign: 0x0000 or 0x8000.
- R7: An infinity converts exactly: 0x7F80 or 0xFF80. A NaN keeps its sign and its top 7 fraction bits and has fraction bit 6 of the BF16 forced to 1, which gives a quiet NaN.
- R8: With `mask_en` low, every element receives its converted value. With `mask_en` high, an element whose bit in `mask` (bit i for element i) is 1 receives its converted value.
- R9: With `mask_en` high and `zero_mode` high, an element whose mask bit is 0 is written as 0x0000.
- R10: With `mask_en` high and `zero_mode` low, an element whose mask bit is 0 takes bits [16i+15:16i] of `old_dst`.
- R11: `result` bits from VEC_W up to MAX_W-1 are always 0, whatever `old_dst` holds. `mask` bits at or above VEC_W/16 have no effect.
- R12: While `in_valid` is low, `result` holds its last value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid; operands are sampled in this cycle |
| src_a | input | VEC_W | First FP32 source vector; feeds the upper half of the result |
| src_b | input | VEC_W | Second FP32 source vector; feeds the lower half, or element 0 for broadcast |
| old_dst | input | MAX_W | Previous destination contents, used for merge masking |
| mask | input | MASK_W | Per-element write mask, bit i for element i |
| mask_en | input | 1 | 1 enables the write mask |
| zero_mode | input | 1 | 1 zeroes masked-off elements, 0 merges them from `old_dst` |
| bcast | input | 1 | 1 uses `src_b` element 0 for every element |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | MAX_W | Packed BF16 result, zero above VEC_W |

## Verification
Conversion and masking act in the same cycle on the same element. A masked-off lane must not let an otherwise visible rounding or NaN result through, and broadcast must still obey the per-lane mask. The bench sends requests in which broadcast and merge or zero masking are active at once, with known FP32 patterns that would convert to distinct values. Each lane is judged against a value derived from the mask bit first and the conversion rule second. Back-to-back requests with different modes check that one request's mode does not carry over into the next.

// File: rtl/bf16_pack_pkg.sv
package bf16_pack_pkg;

   localparam int FP32_W = 32;
   localparam int BF16_W = 16;

   typedef logic [FP32_W-1:0] fp32_t;
   typedef logic [BF16_W-1:0] bf16_t;

   typedef struct packed {
      logic        sign;
      logic [7:0]  expo;
      logic [22:0] frac;
   } fp32_fields_t;

   localparam logic [7:0] EXP_ALL_ONES = 8'hFF;

endpackage

// File: rtl/bf16_round_unit.sv
module bf16_round_unit
   import bf16_pack_pkg::*;
(
   input  fp32_t din,
   output bf16_t dout
);

   fp32_fields_t f;
   logic         is_zero_class;
   logic         is_special;
   logic [31:0]  sum_full;
   bf16_t        rounded;
   logic         unused_low;

   assign f             = fp32_fields_t'(din);
   assign is_zero_class = (f.expo == 8'd0);
   assign is_special    = (f.expo == EXP_ALL_ONES);

   // round to nearest even: add 0x7FFF plus the kept lsb, then truncate
   assign sum_full   = {1'b0, din[30:0]} + 32'h0000_7FFF + {31'd0, din[16]};
   assign rounded    = {f.sign, sum_full[30:16]};
   assign unused_low = ^{sum_full[31], sum_full[15:0]};

   always_comb begin
      if (is_zero_class)
         dout = {f.sign, 15'd0};
      else if (is_special)
         dout = (f.frac == 23'd0) ? {f.sign, EXP_ALL_ONES, 7'd0}
                                  : {f.sign, EXP_ALL_ONES, 1'b1, f.frac[21:16]};
      else
         dout = rounded;
   end

   // R5 R6: a finite normal input never lands in the BF16 zero/denormal range
   always_comb begin
      if (!is_zero_class && !is_special) begin
         no_denorm_out_chk: assert (dout[14:7] != 8'd0)
            else $error("normal input produced zero exponent");
      end
   end

endmodule

// File: rtl/bf16_lane_select.sv
module bf16_lane_select
   import bf16_pack_pkg::*;
#(
   parameter int VEC_W = 512,
   localparam int NELEM = VEC_W / BF16_W,
   localparam int HALF  = NELEM / 2
) (
   input  logic [VEC_W-1:0]              src_a,
   input  logic [VEC_W-1:0]              src_b,
   input  logic                          bcast,
   output logic [NELEM-1:0][FP32_W-1:0]  lanes
);

   genvar i;
   generate
      for (i = 0; i < NELEM; i++) begin : g_lane
         fp32_t pick;
         if (i < HALF) begin : g_low
            assign pick = src_b[i*FP32_W +: FP32_W];
         end else begin : g_high
            assign pick = src_a[(i-HALF)*FP32_W +: FP32_W];
         end
         assign lanes[i] = bcast ? src_b[FP32_W-1:0] : pick;
      end
   endgenerate

endmodule

// File: rtl/bf16_mask_merge.sv
module bf16_mask_merge
   import bf16_pack_pkg::*;
#(
   parameter int NELEM = 32
) (
   input  logic [NELEM-1:0][BF16_W-1:0] conv,
   input  logic [NELEM-1:0][BF16_W-1:0] prior,
   input  logic [NELEM-1:0]             lane_mask,
   input  logic                         mask_en,
   input  logic                         zero_mode,
   output logic [NELEM-1:0][BF16_W-1:0] merged
);

   genvar i;
   generate
      for (i = 0; i < NELEM; i++) begin : g_elem
         logic take;
         assign take = !mask_en || lane_mask[i];
         always_comb begin
            if (take)           merged[i] = conv[i];
            else if (zero_mode) merged[i] = '0;
            else                merged[i] = prior[i];
         end
      end
   endgenerate

endmodule

// File: rtl/bf16_pack_cvt.sv
module bf16_pack_cvt
   import bf16_pack_pkg::*;
#(
   parameter int VEC_W  = 512,
   parameter int MAX_W  = 512,
   parameter int MASK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  src_a,
   input  logic [VEC_W-1:0]  src_b,
   input  logic [MAX_W-1:0]  old_dst,
   input  logic [MASK_W-1:0] mask,
   input  logic              mask_en,
   input  logic              zero_mode,
   input  logic              bcast,
   output logic              out_valid,
   output logic [MAX_W-1:0]  result
);

   localparam int NELEM = VEC_W / BF16_W;

   initial begin
      cfg_width_chk: assert (VEC_W == 128 || VEC_W == 256 || VEC_W == 512)
         else $error("VEC_W must be 128, 256 or 512");
      cfg_max_chk: assert (MAX_W >= VEC_W && MAX_W % BF16_W == 0)
         else $error("MAX_W too small");
      cfg_mask_chk: assert (MASK_W >= NELEM)
         else $error("MASK_W below element count");
   end

   logic [NELEM-1:0][FP32_W-1:0] lanes;
   logic [NELEM-1:0][BF16_W-1:0] conv;
   logic [NELEM-1:0][BF16_W-1:0] merged;
   logic [NELEM-1:0][BF16_W-1:0] prior;
   logic [VEC_W-1:0]             res_q;

   assign prior = old_dst[VEC_W-1:0];

   bf16_lane_select #(.VEC_W(VEC_W)) u_sel (
      .src_a (src_a),
      .src_b (src_b),
      .bcast (bcast),
      .lanes (lanes)
   );

   genvar i;
   generate
      for (i = 0; i < NELEM; i++) begin : g_cvt
         bf16_round_unit u_rnd (
            .din  (lanes[i]),
            .dout (conv[i])
         );
      end
   endgenerate

   bf16_mask_merge #(.NELEM(NELEM)) u_mrg (
      .conv      (conv),
      .prior     (prior),
      .lane_mask (mask[NELEM-1:0]),
      .mask_en   (mask_en),
      .zero_mode (zero_mode),
      .merged    (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) res_q <= merged;
      end
   end

   generate
      if (MAX_W > VEC_W) begin : g_pad
         logic unused_dst;
         assign unused_dst = ^old_dst[MAX_W-1:VEC_W];
         assign result = {{(MAX_W-VEC_W){1'b0}}, res_q};
      end else begin : g_full
         assign result = res_q;
      end
      if (MASK_W > NELEM) begin : g_mask_pad
         logic unused_mask;
         assign unused_mask = ^mask[MASK_W-1:NELEM];
      end
   endgenerate

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R12
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   // R9
   zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && !mask[0] && zero_mode) |=> (result[15:0] == 16'd0));
   // R10
   merge_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && !mask[0] && !zero_mode) |=> (result[15:0] == $past(old_dst[15:0])));
   // R4
   bcast_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bcast && !mask_en) |=> (result[15:0] == result[VEC_W-1 -: 16]));

endmodule

// File: tb/bf16_pack_cvt_test.sv
module bf16_pack_cvt_test;

   localparam int VW = 256;
   localparam int MW = 512;
   localparam int NE = VW / 16;
   localparam int HF = NE / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] src_a = '0;
   logic [VW-1:0] src_b = '0;
   logic [MW-1:0] old_dst = '0;
   logic [31:0]   mask = '0;
   logic          mask_en = 1'b0;
   logic          zero_mode = 1'b0;
   logic          bcast = 1'b0;
   logic          out_valid;
   logic [MW-1:0] result;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bf16_pack_cvt #(.VEC_W(VW), .MAX_W(MW), .MASK_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .src_a(src_a), .src_b(src_b), .old_dst(old_dst), .mask(mask),
      .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
      .out_valid(out_valid), .result(result)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_elem(input int i, input logic [15:0] exp, input string tag);
      check(result[i*16 +: 16] == exp, $sformatf("%s elem %0d", tag, i),
            {48'd0, result[i*16 +: 16]}, {48'd0, exp});
   endtask

   // one request: drive at negedge, drop valid, sample at following negedge
   task automatic issue();
      @(negedge clk); in_valid = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      check(out_valid == 1'b1, "R1 out_valid after request", {63'd0, out_valid}, 64'd1);
   endtask

   function automatic logic [15:0] order_exp(input int i);
      if (i < HF) return {1'b0, 8'(100 + i), 7'(i)};
      else        return {1'b0, 8'(127 + i - HF), 7'd0};
   endfunction

   task automatic load_order();
      for (int k = 0; k < HF; k++) begin
         src_b[k*32 +: 32] = {1'b0, 8'(100 + k), 7'(k), 16'd0};
         src_a[k*32 +: 32] = {1'b0, 8'(127 + k), 23'd0};
      end
   endtask

   task automatic t_reset();
      check(out_valid == 1'b0, "R1 reset out_valid", {63'd0, out_valid}, 64'd0);
      check(result == '0, "R1 reset result", result[63:0], 64'd0);
   endtask

   task automatic t_order();
      load_order(); mask_en = 1'b0; bcast = 1'b0;
      issue();
      for (int i = 0; i < NE; i++)
         check_elem(i, order_exp(i), i < HF ? "R2 low half from src_b" : "R3 high half from src_a");
      check(result[MW-1:VW] == '0, "R11 upper bits zero", result[MW-1 -: 64], 64'd0);
   endtask

   task automatic t_bcast();
      load_order(); src_b[31:0] = 32'h3FC0_0000; bcast = 1'b1; mask_en = 1'b0;
      issue();
      for (int i = 0; i < NE; i++) check_elem(i, 16'h3FC0, "R4 broadcast");
      bcast = 1'b0;
   endtask

   task automatic t_round();
      logic [31:0] bv [8];
      logic [15:0] be [8];
      logic [31:0] av [8];
      logic [15:0] ae [8];
      bv = '{32'h3F80_8000, 32'h3F81_8000, 32'h3F80_8001, 32'h3F80_7FFF,
             32'h7F7F_FFFF, 32'h3FFF_FFFF, 32'hBF80_8000, 32'hC000_0000};
      be = '{16'h3F80, 16'h3F82, 16'h3F81, 16'h3F80,
             16'h7F80, 16'h4000, 16'hBF80, 16'hC000};
      av = '{32'h0000_0001, 32'h807F_FFFF, 32'h7F80_0000, 32'hFF80_0000,
             32'h7F80_0001, 32'hFFA0_0000, 32'h7FC1_2345, 32'h0000_0000};
      ae = '{16'h0000, 16'h8000, 16'h7F80, 16'hFF80,
             16'h7FC0, 16'hFFE0, 16'h7FC1, 16'h0000};
      for (int k = 0; k < HF; k++) begin
         src_b[k*32 +: 32] = bv[k];
         src_a[k*32 +: 32] = av[k];
      end
      mask_en = 1'b0;
      issue();
      for (int k = 0; k < HF; k++) check_elem(k, be[k], "R5 round nearest even");
      for (int k = 0; k < 2; k++)  check_elem(HF + k, ae[k], "R6 denormal to signed zero");
      for (int k = 2; k < HF; k++) check_elem(HF + k, ae[k], "R7 inf/NaN handling");
   endtask

   task automatic t_mask(input bit zm);
      load_order();
      for (int i = 0; i < NE; i++) old_dst[i*16 +: 16] = 16'hD000 + 16'(i);
      mask = 32'h0000_A5C3; mask_en = 1'b1; zero_mode = zm;
      issue();
      for (int i = 0; i < NE; i++) begin
         if (mask[i])  check_elem(i, order_exp(i), "R8 mask set converts");
         else if (zm)  check_elem(i, 16'h0000, "R9 zeroing");
         else          check_elem(i, 16'hD000 + 16'(i), "R10 merging");
      end
      mask_en = 1'b0; zero_mode = 1'b0;
   endtask

   task automatic t_upper();
      load_order(); old_dst = '1;
      mask = 32'hFFFF_0000; mask_en = 1'b1; zero_mode = 1'b1;
      issue();
      for (int i = 0; i < NE; i++) check_elem(i, 16'h0000, "R11 high mask bits ignored");
      check(result[MW-1:VW] == '0, "R11 upper bits zero with ones in old_dst",
            result[MW-1 -: 64], 64'd0);
      mask_en = 1'b0; zero_mode = 1'b0;
   endtask

   // broadcast and merge masking in the same request
   task automatic t_bcast_mask();
      load_order(); src_b[31:0] = 32'h4049_0FDB; bcast = 1'b1;
      for (int i = 0; i < NE; i++) old_dst[i*16 +: 16] = 16'h1200 + 16'(i);
      mask = 32'h0000_0F0F; mask_en = 1'b1; zero_mode = 1'b0;
      issue();
      for (int i = 0; i < NE; i++)
         check_elem(i, mask[i] ? 16'h4049 : 16'h1200 + 16'(i), "R4 broadcast under merge mask");
      bcast = 1'b0; mask_en = 1'b0;
   endtask

   task automatic t_b2b();
      load_order();
      @(negedge clk); in_valid = 1'b1; mask_en = 1'b1; zero_mode = 1'b1; mask = 32'h0;
      @(negedge clk);
      check(out_valid == 1'b1, "R1 first of pair valid", {63'd0, out_valid}, 64'd1);
      check_elem(3, 16'h0000, "R9 first of pair zeroed");
      mask_en = 1'b0;
      @(negedge clk); in_valid = 1'b0;
      check(out_valid == 1'b1, "R1 second of pair valid", {63'd0, out_valid}, 64'd1);
      check_elem(3, order_exp(3), "R8 second of pair unmasked");
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid drops", {63'd0, out_valid}, 64'd0);
      zero_mode = 1'b0;
   endtask

   task automatic t_hold();
      logic [MW-1:0] snap;
      snap = result;
      src_a = '1; src_b = '0; old_dst = '0; mask_en = 1'b1; zero_mode = 1'b1;
      repeat (3) @(negedge clk);
      check(result == snap, "R12 hold while idle", result[63:0], snap[63:0]);
      check(out_valid == 1'b0, "R12 no valid while idle", {63'd0, out_valid}, 64'd0);
      mask_en = 1'b0; zero_mode = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_order();
      t_bcast();
      t_round();
      t_mask(1'b0);
      t_mask(1'b1);
      t_upper();
      t_bcast_mask();
      t_b2b();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule